// File: doc/BRIEF.md
# Glitch-Free Selectable Power-of-Two Clock Divider

This block takes a fast input clock and produces an output clock at the input rate divided by 1, 2, 4 or 8. A 2-bit modulus code picks the ratio. In the three dividing modes the output is a registered square wave with a 50% duty cycle. In bypass (divide-by-1) the output is the input clock itself, passed through a clock gate whose enable is held by a latch that is open only while the input clock is low. The duty cycle of the input clock therefore carries through, and switching into or out of bypass cannot cut a pulse.

An active-high output enable starts and stops the output. The enable passes through a two-stage synchroniser. The modulus code is captured in a register. Both take effect only at a period boundary: the divided output is low and the phase counter is about to wrap to zero. A disabled output is held low, and every pulse that appears has its full nominal width.

The controller has two states. `ST_OFF` holds the output low. `ST_RUN` produces pulses. The transition `OFF->RUN` happens at a boundary where the synchronised enable is high. The transition `RUN->OFF` happens at a boundary where the synchronised enable is low. At each boundary the pending code is loaded as the active code.

Top module: `clkdiv_glitchless`

## Requirements
- R1: While the asynchronous reset is high, the output is low. After reset the block is in the disabled state with a cleared counter, active code 00, and the synchronised enable low.
- R2: The active code selects the ratio: 00 gives divide-by-2, 01 gives divide-by-4, 10 gives divide-by-8, and 11 gives divide-by-1.
- R3: In a dividing mode with ratio D, each output pulse rises on an input rising edge, stays high for D/2 input cycles, then stays low for D/2 cycles.
- R4: In bypass, the output is high exactly during the input clock's high phases, with whole phases only.
- R5: While the block is disabled, the output stays low whatever the modulus code does.
- R6: The enable passes through two flip-flops. A rise of the enable sampled at input edge k can start output at the earliest at edge k+2, and only at a boundary.
- R7: A disable takes effect only at a boundary, so the last pulse before the output stops has its full width.
- R8: The modulus code is registered on each input edge. The registered value becomes active only at a boundary, where the output is low and the counter wraps to zero.
- R9: On entry into bypass, the first gated pulse comes one input cycle after the boundary edge. On exit from bypass, the divided pulse starts at the boundary edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_a | input | 1 | Asynchronous active-high reset |
| div_code | input | 2 | Modulus code (00:/2, 01:/4, 10:/8, 11:/1) |
| out_en | input | 1 | Active-high output enable, asynchronous to the divider's phase |
| clk_out | output | 1 | Divided or gated clock output |

## Verification
The bench builds the block with its default parameters: a two-stage enable synchroniser and a 3-bit phase counter. With these values all four ratios and every transition between them are reachable in a few dozen cycles. A behavioural model in the bench predicts the output in each half of every input cycle and is compared in both halves. This catches a runt, a late edge or a lost pulse when the enable toggles in mid-pulse, when the code changes at arbitrary phases, and when the block moves into or out of bypass.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CODE_W = 2;
    localparam int CNT_W  = 3;
    localparam int RAT_W  = CNT_W + 1;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } dstate_t;

    // Non-binary modulus code: 00 /2, 01 /4, 10 /8, 11 /1
    function automatic logic [RAT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [RAT_W-1:0] r;
        unique case (code)
            2'b00:   r = RAT_W'(2);
            2'b01:   r = RAT_W'(4);
            2'b10:   r = RAT_W'(8);
            default: r = RAT_W'(1);
        endcase
        return r;
    endfunction

    function automatic logic is_bypass(input logic [CODE_W-1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) begin
                    chain_q[i] <= 1'b0;
                end else begin
                    chain_q[i] <= (i == 0) ? d_i : chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              div_o,
    output logic              gate_o
);
    dstate_t           state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [CODE_W-1:0] pend_q;
    logic [CODE_W-1:0] act_q, act_n;
    logic              div_q, div_n;
    logic              gate_q, gate_n;
    logic              boundary;
    logic [RAT_W-1:0]  last_cnt;
    logic [RAT_W-1:0]  half_n;

    assign last_cnt = ratio_of(act_q) - RAT_W'(1);
    assign boundary = (state_q == ST_OFF) || ({1'b0, cnt_q} == last_cnt);

    // Next-state process
    always_comb begin
        state_n = state_q;
        act_n   = act_q;
        cnt_n   = cnt_q + CNT_W'(1);
        if (boundary) begin
            act_n = pend_q;
            cnt_n = '0;
            unique case (state_q)
                ST_OFF: state_n = en_i ? ST_RUN : ST_OFF;
                ST_RUN: state_n = en_i ? ST_RUN : ST_OFF;
            endcase
        end
    end

    // Output process
    assign half_n = ratio_of(act_n) >> 1;
    always_comb begin
        div_n  = 1'b0;
        gate_n = 1'b0;
        unique case (state_n)
            ST_OFF: begin
                div_n  = 1'b0;
                gate_n = 1'b0;
            end
            ST_RUN: begin
                gate_n = is_bypass(act_n);
                div_n  = !is_bypass(act_n) && ({1'b0, cnt_n} < half_n);
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            pend_q  <= '0;
            act_q   <= '0;
            div_q   <= 1'b0;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            pend_q  <= code_i;
            act_q   <= act_n;
            div_q   <= div_n;
            gate_q  <= gate_n;
        end
    end

    assign div_o  = div_q;
    assign gate_o = gate_q;

    assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        {1'b0, cnt_q} <= last_cnt);

    assert_pulse_start_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(div_q) |-> (cnt_q == '0));

    assert_code_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !boundary |=> $stable(act_q));

    assert_off_quiet_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_OFF) |-> (!div_q && !gate_q));

    assert_bypass_entry_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_q) |-> !$past(div_q));
endmodule

// File: rtl/clkdiv_bypass_gate.sv
module clkdiv_bypass_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic gate_i,
    input  logic div_i,
    output logic clk_o
);
    logic gate_l;

    // Open only in the low phase, so the gate cannot change under a high pulse
    always_latch begin
        if (rst_i) begin
            gate_l = 1'b0;
        end else if (!clk_i) begin
            gate_l = gate_i;
        end
    end

    assign clk_o = (clk_i & gate_l) | div_i;
endmodule

// File: rtl/clkdiv_glitchless.sv
module clkdiv_glitchless
    import clkdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_in,
    input  logic              rst_a,
    input  logic [CODE_W-1:0] div_code,
    input  logic              out_en,
    output logic              clk_out
);
    logic en_s;
    logic div_w;
    logic gate_w;

    clkdiv_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_in),
        .rst_i (rst_a),
        .d_i   (out_en),
        .q_o   (en_s)
    );

    clkdiv_core u_core (
        .clk_i  (clk_in),
        .rst_i  (rst_a),
        .en_i   (en_s),
        .code_i (div_code),
        .div_o  (div_w),
        .gate_o (gate_w)
    );

    clkdiv_bypass_gate u_gate (
        .clk_i  (clk_in),
        .rst_i  (rst_a),
        .gate_i (gate_w),
        .div_i  (div_w),
        .clk_o  (clk_out)
    );

    always_ff @(posedge clk_in) begin
        if (rst_a) begin
            assert_reset_low_R1: assert (clk_out === 1'b0);
        end
    end

    assert_bypass_exclusive_R4: assert property (@(posedge clk_in) disable iff (rst_a)
        !(div_w && gate_w));
endmodule

// File: tb/tb_clkdiv_glitchless.sv
`timescale 1ns/1ps
module tb_clkdiv_glitchless;
    logic       clk_in = 1'b0;
    logic       rst_a  = 1'b1;
    logic [1:0] div_code = 2'b00;
    logic       out_en = 1'b0;
    logic       clk_out;

    int checks = 0;
    int bad    = 0;
    bit model_on = 1'b0;
    string tag = "R1";

    clkdiv_glitchless dut (
        .clk_in   (clk_in),
        .rst_a    (rst_a),
        .div_code (div_code),
        .out_en   (out_en),
        .clk_out  (clk_out)
    );

    always #5 clk_in = ~clk_in;

    function automatic int rat(input logic [1:0] c);
        case (c)
            2'b00:   return 2;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%b exp=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge
    int   m_ratio = 2;
    int   m_pos   = 0;
    bit   m_run   = 0;
    bit   m_gcur  = 0;
    bit   m_gprev = 0;
    bit   en_p1 = 0, en_p2 = 0;
    logic [1:0] md_p1 = 2'b00;

    always @(posedge clk_in) begin
        if (model_on) begin
            bit d;
            if (!m_run || m_pos == m_ratio - 1) begin
                m_ratio = rat(md_p1);   // R8: registered code applied at boundary
                m_run   = en_p2;        // R6/R7: synchronised enable at boundary
                m_pos   = 0;
            end else begin
                m_pos++;
            end
            en_p2 = en_p1;
            en_p1 = out_en;
            md_p1 = div_code;
            m_gprev = m_gcur;
            m_gcur  = m_run && (m_ratio == 1);
            d = m_run && (m_ratio != 1) && (m_pos < m_ratio / 2);
            #2.5;
            chk(clk_out, m_gprev | d, "high phase");
            @(negedge clk_in);
            #2.5;
            chk(clk_out, d, "low phase");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk_in);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: got=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        // R1: output low throughout reset
        tag = "R1";
        for (int i = 0; i < 6; i++) begin
            #3.5;
            chk(clk_out, 1'b0, "during reset");
            @(negedge clk_in);
        end
        rst_a = 1'b0;
        model_on = 1'b1;

        // R5: disabled, code wiggling has no effect
        tag = "R5";
        for (int i = 0; i < 4; i++) begin
            div_code = 2'(i);
            step(5);
        end

        // R6, R2, R3: enable, divide-by-2 then /4 then /8
        tag = "R6"; div_code = 2'b00; out_en = 1'b1; step(6);
        tag = "R2"; step(20);
        tag = "R3"; div_code = 2'b01; step(40);
        tag = "R3"; div_code = 2'b10; step(48);
        // R4, R9: into bypass, stay, then out
        tag = "R9"; div_code = 2'b11; step(10);
        tag = "R4"; step(20);
        tag = "R9"; div_code = 2'b00; step(12);
        // R7: disable in mid-pulse of /8
        tag = "R7"; div_code = 2'b10; step(11);
        out_en = 1'b0; step(30);
        // R6: short enable blip and re-enable mid-phase
        tag = "R6"; out_en = 1'b1; step(1); out_en = 1'b0; step(20);
        out_en = 1'b1; step(25);
        // R8: code changes at odd phases, including short-lived values
        tag = "R8";
        div_code = 2'b01; step(3);
        div_code = 2'b11; step(1);
        div_code = 2'b10; step(7);
        div_code = 2'b00; step(2);
        div_code = 2'b11; step(13);
        // R7 in bypass: disable
        tag = "R7"; out_en = 1'b0; step(12);

        // Mixed random stimulus across all requirements (R2 R3 R4 R6 R7 R8 R9)
        tag = "R2";
        lf = 32'h1d2c3b4a;
        for (int i = 0; i < 300; i++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            div_code = lf[17:16];
            if (lf[20:18] == 3'd0) out_en = ~out_en;
            else if (lf[23:21] < 3'd5) out_en = 1'b1;
            step(1 + int'(lf[27:24]));
        end
        out_en = 1'b0;
        step(20);

        // R1: asynchronous reset in mid-run forces output low
        tag = "R1";
        model_on = 1'b0;
        @(posedge clk_in);
        #1;
        rst_a = 1'b1;
        #1;
        chk(clk_out, 1'b0, "async reset");
        step(2);
        #2.5;
        chk(clk_out, 1'b0, "held in reset");
        finish_run();
    end
endmodule